// File: doc/BRIEF.md
# Bus access match comparator unit

The unit watches every processor bus cycle and compares it against a set of programmable comparator channels. By default there are three, A, B and C. Each channel holds a reference address and a set of control bits. A channel fires a one-cycle match pulse when a bus cycle qualifies. Match bit 0 belongs to channel A, bit 1 to B and bit 2 to C.

In direct mode, a channel matches in the cycle after its address appears on the bus. An opcode fetch counts as such a bus cycle. The match can be narrowed by access direction. Channels A and B can also narrow it by access size, and channel C has no size qualification. The address compare is exact, so a word access that starts one byte lower does not match.

In tag mode, the channel ignores the direction and size qualifiers. It marks the opcode fetched at its address and fires only when the pipeline reports that this instruction has reached the execute stage. A pipeline flush discards every pending mark.

Top module: `bus_match_unit`

## Requirements
- R1: Output `match[i]` is driven by channel i (bit 0 = A, bit 1 = B, bit 2 = C). All match bits are 0 during reset and in the first cycle after reset.
- R2: In direct mode, a valid bus cycle whose `bus_addr` equals the channel address raises `match[i]` for exactly the following cycle. A word access to the address minus one does not match. A cycle with `bus_valid` = 0 never matches.
- R3: With `cfg_rwe[i]` = 1, only accesses with `bus_rd` equal to `cfg_rw[i]` match (1 = read, 0 = write). With `cfg_rwe[i]` = 0, both reads and writes match.
- R4: On channels A and B, `cfg_sze[i]` = 1 limits matches to accesses with `bus_word` equal to `cfg_sz[i]` (1 = word, 0 = byte). A channel set for byte access does not match a word access at its address.
- R5: Channel C has no size qualification. Its `cfg_sze` and `cfg_sz` bits have no effect.
- R6: A direct-mode match is also produced by an opcode fetch at the address, in the cycle after the fetch. Each qualifying bus cycle gives one pulse, and later non-qualifying cycles give none.
- R7: With `cfg_tag[i]` = 1, an opcode fetch (`bus_fetch` = 1) at the channel address sets a pending tag and does not match, whatever the direction and size qualifiers say. `match[i]` pulses in the cycle after `ex_valid` = 1 with `ex_addr` equal to the channel address while that tag is pending.
- R8: A tag is consumed by the match it produces. A second execute report without a new fetch gives no match.
- R9: `flush` = 1 clears all pending tags without a match. This holds even when an execute report arrives in the same cycle.
- R10: With `cfg_en[i]` = 0, channel i never matches, in either mode.
- R11: In tag mode, a non-fetch access at the channel address sets no tag. A following execute report gives no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus cycle present |
| bus_addr | input | AW | Bus address |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| bus_fetch | input | 1 | Cycle is an opcode fetch |
| ex_valid | input | 1 | An instruction enters the execute stage |
| ex_addr | input | AW | Opcode address of the executing instruction |
| flush | input | 1 | Pipeline flush, drops pending tags |
| cfg_addr | input | NUM_CH*AW | Channel reference addresses, channel i at bits [i*AW +: AW] |
| cfg_en | input | NUM_CH | Channel enable |
| cfg_tag | input | NUM_CH | Tag mode select |
| cfg_rwe | input | NUM_CH | Direction qualification enable |
| cfg_rw | input | NUM_CH | Direction that matches (1 = read) |
| cfg_sze | input | NUM_CH | Size qualification enable (size-capable channels only) |
| cfg_sz | input | NUM_CH | Size that matches (1 = word) |
| match | output | NUM_CH | Registered single-cycle match pulses |

## Verification
The hardest states to reach are the tag-mode corners: a pending tag that meets a flush in the same cycle as its execute report, and a second execute report after the tag has been consumed. The stimulus reaches them with short scripted sequences on channel B, which has restrictive direction and size qualifiers set. A fetch is followed either by a flush with a coincident execute report or by two execute reports in a row. A read fetch that would fail the write-only qualifier is also used, so it shows that tag mode ignores those bits. The exact-address corner is reached by issuing a word access one byte below a loaded address.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
   typedef struct packed {
      logic en;
      logic tag;
      logic rwe;
      logic rw;
      logic sze;
      logic sz;
   } bmu_ctrl_t;
endpackage

// File: rtl/bmu_qualify.sv
module bmu_qualify
   import bmu_pkg::*;
#(
   parameter int AW      = 16,
   parameter bit SIZE_EN = 1'b1
) (
   input  bmu_ctrl_t         ctrl,
   input  logic [AW-1:0]     ref_addr,
   input  logic              bus_valid,
   input  logic [AW-1:0]     bus_addr,
   input  logic              bus_rd,
   input  logic              bus_word,
   output logic              addr_hit,
   output logic              direct_hit
);
   logic dir_ok;
   logic size_ok;

   assign addr_hit = bus_valid && (bus_addr == ref_addr);
   assign dir_ok   = !ctrl.rwe || (bus_rd == ctrl.rw);

   generate
      if (SIZE_EN) begin : g_size
         assign size_ok = !ctrl.sze || (bus_word == ctrl.sz);
      end else begin : g_nosize
         logic unused_size;
         assign unused_size = ctrl.sze ^ ctrl.sz ^ bus_word;
         assign size_ok     = 1'b1;
      end
   endgenerate

   assign direct_hit = addr_hit && dir_ok && size_ok;
endmodule

// File: rtl/bmu_tag_track.sv
module bmu_tag_track
   import bmu_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  bmu_ctrl_t     ctrl,
   input  logic [AW-1:0] ref_addr,
   input  logic          addr_hit,
   input  logic          bus_fetch,
   input  logic          ex_valid,
   input  logic [AW-1:0] ex_addr,
   input  logic          flush,
   output logic          exec_hit
);
   logic armed;
   logic pending_q;
   logic capture;

   assign armed    = ctrl.en && ctrl.tag;
   assign capture  = armed && addr_hit && bus_fetch;
   assign exec_hit = armed && pending_q && !flush &&
                     ex_valid && (ex_addr == ref_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pending_q <= 1'b0;
      else if (!armed)     pending_q <= 1'b0;
      else if (flush)      pending_q <= 1'b0;
      else if (capture)    pending_q <= 1'b1;
      else if (exec_hit)   pending_q <= 1'b0;
   end
endmodule

// File: rtl/bmu_channel.sv
module bmu_channel
   import bmu_pkg::*;
#(
   parameter int AW      = 16,
   parameter bit SIZE_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  bmu_ctrl_t     ctrl,
   input  logic [AW-1:0] ref_addr,
   input  logic          bus_valid,
   input  logic [AW-1:0] bus_addr,
   input  logic          bus_rd,
   input  logic          bus_word,
   input  logic          bus_fetch,
   input  logic          ex_valid,
   input  logic [AW-1:0] ex_addr,
   input  logic          flush,
   output logic          match_o
);
   logic addr_hit;
   logic direct_hit;
   logic exec_hit;
   logic match_d;

   bmu_qualify #(.AW(AW), .SIZE_EN(SIZE_EN)) u_qual (
      .ctrl       (ctrl),
      .ref_addr   (ref_addr),
      .bus_valid  (bus_valid),
      .bus_addr   (bus_addr),
      .bus_rd     (bus_rd),
      .bus_word   (bus_word),
      .addr_hit   (addr_hit),
      .direct_hit (direct_hit)
   );

   bmu_tag_track #(.AW(AW)) u_tag (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl      (ctrl),
      .ref_addr  (ref_addr),
      .addr_hit  (addr_hit),
      .bus_fetch (bus_fetch),
      .ex_valid  (ex_valid),
      .ex_addr   (ex_addr),
      .flush     (flush),
      .exec_hit  (exec_hit)
   );

   assign match_d = ctrl.en && (ctrl.tag ? exec_hit : direct_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_o <= 1'b0;
      else        match_o <= match_d;
   end
endmodule

// File: rtl/bus_match_unit.sv
module bus_match_unit
   import bmu_pkg::*;
#(
   parameter int AW           = 16,
   parameter int NUM_CH       = 3,
   parameter int SIZE_QUAL_CH = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_valid,
   input  logic [AW-1:0]        bus_addr,
   input  logic                 bus_rd,
   input  logic                 bus_word,
   input  logic                 bus_fetch,
   input  logic                 ex_valid,
   input  logic [AW-1:0]        ex_addr,
   input  logic                 flush,
   input  logic [NUM_CH*AW-1:0] cfg_addr,
   input  logic [NUM_CH-1:0]    cfg_en,
   input  logic [NUM_CH-1:0]    cfg_tag,
   input  logic [NUM_CH-1:0]    cfg_rwe,
   input  logic [NUM_CH-1:0]    cfg_rw,
   input  logic [NUM_CH-1:0]    cfg_sze,
   input  logic [NUM_CH-1:0]    cfg_sz,
   output logic [NUM_CH-1:0]    match
);
   localparam int ADDR_BITS = NUM_CH * AW;

   generate
      if (AW < 2) begin : g_bad_aw
         $error("bus_match_unit: AW must be at least 2");
      end
      if (NUM_CH < 1) begin : g_bad_ch
         $error("bus_match_unit: NUM_CH must be at least 1");
      end
      if (SIZE_QUAL_CH > NUM_CH || SIZE_QUAL_CH < 0) begin : g_bad_sq
         $error("bus_match_unit: SIZE_QUAL_CH out of range");
      end
      if (ADDR_BITS != $bits(cfg_addr)) begin : g_bad_pack
         $error("bus_match_unit: address bus packing mismatch");
      end
   endgenerate

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         bmu_ctrl_t ctrl;
         assign ctrl.en  = cfg_en[i];
         assign ctrl.tag = cfg_tag[i];
         assign ctrl.rwe = cfg_rwe[i];
         assign ctrl.rw  = cfg_rw[i];
         assign ctrl.sze = cfg_sze[i];
         assign ctrl.sz  = cfg_sz[i];

         bmu_channel #(.AW(AW), .SIZE_EN(i < SIZE_QUAL_CH)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctrl      (ctrl),
            .ref_addr  (cfg_addr[i*AW +: AW]),
            .bus_valid (bus_valid),
            .bus_addr  (bus_addr),
            .bus_rd    (bus_rd),
            .bus_word  (bus_word),
            .bus_fetch (bus_fetch),
            .ex_valid  (ex_valid),
            .ex_addr   (ex_addr),
            .flush     (flush),
            .match_o   (match[i])
         );
      end
   endgenerate
endmodule

// File: rtl/bmu_checker.sv
module bmu_checker #(
   parameter int AW           = 16,
   parameter int NUM_CH       = 3,
   parameter int SIZE_QUAL_CH = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_valid,
   input logic [AW-1:0]        bus_addr,
   input logic                 bus_rd,
   input logic                 bus_word,
   input logic                 bus_fetch,
   input logic                 ex_valid,
   input logic [AW-1:0]        ex_addr,
   input logic                 flush,
   input logic [NUM_CH*AW-1:0] cfg_addr,
   input logic [NUM_CH-1:0]    cfg_en,
   input logic [NUM_CH-1:0]    cfg_tag,
   input logic [NUM_CH-1:0]    cfg_rwe,
   input logic [NUM_CH-1:0]    cfg_rw,
   input logic [NUM_CH-1:0]    cfg_sze,
   input logic [NUM_CH-1:0]    cfg_sz,
   input logic [NUM_CH-1:0]    match
);
   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
         a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_en[i] |=> !match[i]);

         a_r3_dir_block: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_en[i] && !cfg_tag[i] && cfg_rwe[i] && (bus_rd != cfg_rw[i]))
            |=> !match[i]);

         a_r2_direct_hit: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_en[i] && !cfg_tag[i] && !cfg_rwe[i] && !cfg_sze[i] && bus_valid &&
             (bus_addr == cfg_addr[i*AW +: AW])) |=> match[i]);

         a_r7_exec_only: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_en[i] && cfg_tag[i] && !ex_valid) |=> !match[i]);

         a_r9_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_en[i] && cfg_tag[i] && flush) |=> !match[i]);
      end
   endgenerate
endmodule

bind bus_match_unit bmu_checker #(.AW(AW), .NUM_CH(NUM_CH), .SIZE_QUAL_CH(SIZE_QUAL_CH)) u_bmu_chk (.*);

// File: tb/bus_match_unit_bench.sv
module bus_match_unit_bench;
   localparam int AW = 16;
   localparam int NC = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_valid = 0, bus_rd = 0, bus_word = 0, bus_fetch = 0;
   logic [AW-1:0] bus_addr = '0;
   logic          ex_valid = 0, flush = 0;
   logic [AW-1:0] ex_addr = '0;
   logic [NC*AW-1:0] cfg_addr = '0;
   logic [NC-1:0] cfg_en = '0, cfg_tag = '0, cfg_rwe = '0, cfg_rw = '0,
                  cfg_sze = '0, cfg_sz = '0;
   logic [NC-1:0] match;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [NC-1:0] exp_q[$];
   string         lbl_q[$];

   always #2 clk = ~clk;

   bus_match_unit #(.AW(AW), .NUM_CH(NC), .SIZE_QUAL_CH(2)) u_bus_match_unit (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
      .bus_rd(bus_rd), .bus_word(bus_word), .bus_fetch(bus_fetch),
      .ex_valid(ex_valid), .ex_addr(ex_addr), .flush(flush),
      .cfg_addr(cfg_addr), .cfg_en(cfg_en), .cfg_tag(cfg_tag), .cfg_rwe(cfg_rwe),
      .cfg_rw(cfg_rw), .cfg_sze(cfg_sze), .cfg_sz(cfg_sz), .match(match)
   );

   // monitor: one expected vector per clock after each driven cycle
   always begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
         logic [NC-1:0] e;
         string l;
         e = exp_q.pop_front();
         l = lbl_q.pop_front();
         checks++;
         if (match !== e) begin
            errors++;
            $display("FAIL %s: match actual %b expected %b", l, match, e);
         end
      end
   end

   task automatic bus(input logic v, input logic [AW-1:0] a, input logic rd,
                      input logic wd, input logic f);
      bus_valid = v; bus_addr = a; bus_rd = rd; bus_word = wd; bus_fetch = f;
   endtask

   task automatic step(input logic [NC-1:0] e, input string l);
      exp_q.push_back(e);
      lbl_q.push_back(l);
      @(negedge clk);
      bus(0, '0, 0, 0, 0);
      ex_valid = 0; ex_addr = '0; flush = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hang expected completion");
      finish_run();
   end

   initial begin
      cfg_addr = {16'h3000, 16'h2000, 16'h1000};
      cfg_en = 3'b111;
      repeat (3) @(negedge clk);
      checks++;
      if (match !== 3'b000) begin
         errors++; $display("FAIL R1 reset: actual %b expected 000", match);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (match !== 3'b000) begin
         errors++; $display("FAIL R1 after reset: actual %b expected 000", match);
      end

      bus(1, 16'h1000, 1, 0, 0); step(3'b001, "R1 channel A bit0");
      bus(1, 16'h2000, 0, 0, 0); step(3'b010, "R1 channel B bit1");
      bus(1, 16'h3000, 1, 1, 0); step(3'b100, "R1 channel C bit2");
      bus(1, 16'h0FFF, 1, 1, 0); step(3'b000, "R2 word at n-1");
      bus(0, 16'h1000, 1, 0, 0); step(3'b000, "R2 invalid cycle");
      bus(1, 16'h1001, 1, 0, 0); step(3'b000, "R2 near address");

      cfg_rwe[0] = 1; cfg_rw[0] = 1;
      bus(1, 16'h1000, 0, 0, 0); step(3'b000, "R3 write vs read-only");
      bus(1, 16'h1000, 1, 0, 0); step(3'b001, "R3 read vs read-only");
      cfg_rw[0] = 0;
      bus(1, 16'h1000, 0, 0, 0); step(3'b001, "R3 write vs write-only");
      cfg_rwe[0] = 0;

      cfg_sze[0] = 1; cfg_sz[0] = 0;
      bus(1, 16'h1000, 1, 1, 0); step(3'b000, "R4 A word vs byte-only");
      bus(1, 16'h1000, 1, 0, 0); step(3'b001, "R4 A byte vs byte-only");
      cfg_sze[1] = 1; cfg_sz[1] = 1;
      bus(1, 16'h2000, 1, 0, 0); step(3'b000, "R4 B byte vs word-only");
      bus(1, 16'h2000, 1, 1, 0); step(3'b010, "R4 B word vs word-only");
      cfg_sze = '0; cfg_sz = '0;

      cfg_sze[2] = 1; cfg_sz[2] = 0;
      bus(1, 16'h3000, 1, 1, 0); step(3'b100, "R5 C ignores size bits");
      cfg_sz[2] = 1;
      bus(1, 16'h3000, 1, 0, 0); step(3'b100, "R5 C ignores size word");
      cfg_sze = '0; cfg_sz = '0;

      bus(1, 16'h1000, 1, 1, 1); step(3'b001, "R6 fetch matches at fetch");
      bus(1, 16'h1002, 1, 1, 1); step(3'b000, "R6 no recheck later");

      cfg_en[0] = 0;
      bus(1, 16'h1000, 1, 0, 0); step(3'b000, "R10 disabled direct");
      cfg_en[0] = 1;

      // tag mode on B with restrictive qualifiers
      cfg_tag[1] = 1; cfg_rwe[1] = 1; cfg_rw[1] = 0; cfg_sze[1] = 1; cfg_sz[1] = 0;
      bus(1, 16'h2000, 1, 1, 1); step(3'b000, "R7 no match at tag fetch");
      bus(1, 16'h2002, 1, 1, 1); step(3'b000, "R7 pending, no exec");
      ex_valid = 1; ex_addr = 16'h2000; step(3'b010, "R7 match at execute");
      ex_valid = 1; ex_addr = 16'h2000; step(3'b000, "R8 second execute");

      bus(1, 16'h2000, 1, 1, 0); step(3'b000, "R11 non-fetch access");
      ex_valid = 1; ex_addr = 16'h2000; step(3'b000, "R11 execute without tag");

      bus(1, 16'h2000, 1, 1, 1); step(3'b000, "R9 fetch before flush");
      flush = 1; step(3'b000, "R9 flush cycle");
      ex_valid = 1; ex_addr = 16'h2000; step(3'b000, "R9 execute after flush");

      bus(1, 16'h2000, 1, 1, 1); step(3'b000, "R9 fetch again");
      flush = 1; ex_valid = 1; ex_addr = 16'h2000; step(3'b000, "R9 flush with execute");

      bus(1, 16'h2000, 1, 1, 1); step(3'b000, "R7 refetch");
      ex_valid = 1; ex_addr = 16'h2002; step(3'b000, "R7 execute other address");
      ex_valid = 1; ex_addr = 16'h2000; step(3'b010, "R7 execute tagged");

      bus(1, 16'h2000, 1, 1, 1); step(3'b000, "R10 tag fetch then disable");
      cfg_en[1] = 0;
      ex_valid = 1; ex_addr = 16'h2000; step(3'b000, "R10 disabled tag exec");

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule